// File: doc/BRIEF.md
# Masked Scalar Single-Precision Square Root Lane Unit

This unit computes the IEEE 754 single-precision square root of one 32-bit operand and assembles it into a 128-bit vector word. The low 32 bits of the result carry the root. The upper 96 bits are copied from a separate first-source input. A writemask bit can block the low-lane write. When it does, the low lane either keeps the prior destination value (merge) or becomes zero (zeroing).

The rounding mode comes from one of two places, chosen per operation. It is the override field when embedded rounding is requested and the operand is a register. Otherwise it is the rounding field of the control/status register.

The root of the significand is built by a restoring digit recurrence at one bit per clock. The recurrence produces 24 significand bits plus a guard bit, and the final remainder acts as the sticky bit. Special operands bypass the recurrence. Three exception flags accompany each result: invalid, denormal and inexact.

The operand side is a valid/ready stream. `in_ready` is high only while the unit is idle. An operation is taken on a clock edge where both `in_valid` and `in_ready` are high. A producer facing low `in_ready` must hold `in_valid` and the operand fields steady until it is accepted. The result side has no back-pressure: `out_valid` is a one-cycle completion pulse, and the result and flags stay on the outputs until the next completion.

Top module: `fsq_sqrt_unit`

## Requirements
- R1: For a positive finite nonzero operand, result bits 31:0 are the square root rounded per the effective mode. Mode encodings: 2'b00 nearest-even, 2'b01 toward minus infinity, 2'b10 toward plus infinity, 2'b11 toward zero.
- R2: The effective mode is `rc_override` when `emb_round_en` and `src_is_reg` are both 1. In every other case it is `csr_rc`.
- R3: Result bits 127:32 equal `src1_upper` as sampled at acceptance.
- R4: When `mask_en` is 0 or `mask_bit` is 1, the low lane receives the root. Otherwise the low lane becomes `dst_prev_lo` when `zero_mask` is 0, or 0 when `zero_mask` is 1, and all three flags are 0.
- R5: A negative nonzero operand that is not a NaN, including minus infinity, yields 32'hFFC00000 with the invalid flag set.
- R6: +0 yields +0 and -0 yields -0, with invalid and inexact clear. +infinity yields +infinity.
- R7: A quiet NaN (bit 22 set) is returned unchanged without the invalid flag. A signalling NaN is returned with bit 22 set and the invalid flag raised.
- R8: The denormal flag is 1 exactly when the operand's exponent field is 0 and its fraction is nonzero.
- R9: The inexact flag is 1 exactly when the discarded guard bit or the remainder is nonzero. It is never set for special operands.
- R10: `in_ready` is high only when idle. `out_valid` pulses for one cycle. The pulse comes 26 cycles after acceptance for a positive finite nonzero operand and 1 cycle after acceptance for any other operand.
- R11: `result` and all flags hold their values in every cycle without `out_valid`. After reset they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle, can accept |
| src2_lo | input | 32 | Operand whose root is taken |
| src1_upper | input | 96 | Source for result bits 127:32 |
| dst_prev_lo | input | 32 | Prior destination low lane, used when merging |
| csr_rc | input | 2 | Rounding field of the control/status register |
| emb_round_en | input | 1 | Request to use the per-operation rounding override |
| src_is_reg | input | 1 | Operand comes from a register |
| rc_override | input | 2 | Per-operation rounding mode |
| mask_en | input | 1 | Writemask in use |
| mask_bit | input | 1 | Writemask bit for the low lane |
| zero_mask | input | 1 | 1 = zeroing, 0 = merging, when masked off |
| out_valid | output | 1 | One-cycle completion pulse |
| result | output | 128 | Assembled result word |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_denormal | output | 1 | Denormal-operand flag |
| flag_inexact | output | 1 | Inexact (precision) flag |

## Verification
The checker assumes that a producer never drops or changes an offer while `in_ready` is low. It also assumes that reset is held long enough for the idle state to be reached before the first offer. The stimulus satisfies both. Every offer is raised just after a clock edge and kept unchanged until an edge where `in_ready` was already high, and it is withdrawn right after that edge. The flag properties rely on flags being reported only on the completion word of an unmasked lane. The masked-off test cases therefore always expect all flags clear.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int VEC_W  = 128;
  localparam int UPR_W  = VEC_W - WORD_W;
  localparam int SIG_W  = FRAC_W + 1;          // significand with hidden bit
  localparam int ROOT_W = SIG_W + 1;           // significand plus guard bit
  localparam int RAD_W  = 2 * ROOT_W;          // radicand width
  localparam int CNT_W  = $clog2(ROOT_W);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam logic [WORD_W-1:0] DEFAULT_NAN = 32'hFFC0_0000;
  localparam logic [WORD_W-1:0] QUIET_MASK  = 32'h0040_0000;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_mode_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ITER, ST_FIN} fsq_state_t;
endpackage

// File: rtl/fsq_unpack.sv
module fsq_unpack
  import fsq_pkg::*;
(
  input  logic [WORD_W-1:0] op,
  output logic              special,
  output logic [WORD_W-1:0] special_val,
  output logic              special_inv,
  output logic              subnormal,
  output logic [RAD_W-1:0]  radicand,
  output logic [EXP_W-1:0]  root_exp
);
  localparam int LZ_W = $clog2(FRAC_W + 1);

  logic              sgn, ex_max, ex_zero, fr_zero;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic [LZ_W-1:0]   lz;
  logic [SIG_W-1:0]  sig;
  logic [ROOT_W-1:0] rsig;
  int                eu;
  logic              odd;

  assign sgn     = op[WORD_W-1];
  assign ex      = op[WORD_W-2 -: EXP_W];
  assign fr      = op[FRAC_W-1:0];
  assign ex_max  = &ex;
  assign ex_zero = ~|ex;
  assign fr_zero = ~|fr;
  assign subnormal = ex_zero & ~fr_zero;

  // distance of the leading one below the top fraction bit
  always_comb begin
    lz = '0;
    for (int i = 0; i < FRAC_W; i++)
      if (fr[i]) lz = LZ_W'(FRAC_W - 1 - i);
  end

  always_comb begin
    special     = 1'b1;
    special_inv = 1'b0;
    special_val = op;
    if (ex_max && !fr_zero) begin
      special_val = op | QUIET_MASK;
      special_inv = ~fr[FRAC_W-1];
    end else if (ex_zero && fr_zero) begin
      special_val = op;
    end else if (sgn) begin
      special_val = DEFAULT_NAN;
      special_inv = 1'b1;
    end else if (ex_max) begin
      special_val = op;
    end else begin
      special = 1'b0;
    end
  end

  // normalize, then make the exponent even by widening the significand
  always_comb begin
    if (ex_zero) begin
      sig = {1'b0, fr} << (lz + 1);
      eu  = -BIAS - int'(lz);
    end else begin
      sig = {1'b1, fr};
      eu  = int'(ex) - BIAS;
    end
    odd      = eu[0];
    rsig     = odd ? {sig, 1'b0} : {1'b0, sig};
    radicand = {rsig, {ROOT_W{1'b0}}};
    root_exp = EXP_W'((eu - int'(odd)) / 2 + BIAS);
  end
endmodule

// File: rtl/fsq_root_iter.sv
module fsq_root_iter #(
  parameter int Q_W   = 25,
  parameter int RAD_W = 2 * Q_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [RAD_W-1:0] radicand_in,
  output logic [Q_W-2:0]   root_lo,
  output logic             rem_nz
);
  localparam int REM_W = Q_W + 3;

  logic [RAD_W-1:0] rad;
  logic [REM_W-1:0] rem, rem_sh, trial;
  logic [Q_W-1:0]   q;
  logic             fits;

  assign rem_sh = {rem[REM_W-3:0], rad[RAD_W-1 -: 2]};
  assign trial  = REM_W'({q, 2'b01});
  assign fits   = rem_sh >= trial;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rad <= '0;
      rem <= '0;
      q   <= '0;
    end else if (load) begin
      rad <= radicand_in;
      rem <= '0;
      q   <= '0;
    end else if (step) begin
      rad <= rad << 2;
      rem <= fits ? rem_sh - trial : rem_sh;
      q   <= {q[Q_W-2:0], fits};
    end
  end

  assign root_lo = q[Q_W-2:0];
  assign rem_nz  = |rem;
endmodule

// File: rtl/fsq_round.sv
module fsq_round
  import fsq_pkg::*;
(
  input  logic [SIG_W-1:0]  root_lo,
  input  logic              rem_nz,
  input  logic [EXP_W-1:0]  root_exp,
  input  rnd_mode_t         mode,
  output logic [WORD_W-1:0] value,
  output logic              inexact
);
  logic guard, lsb, up;

  assign guard   = root_lo[0];
  assign lsb     = root_lo[1];
  assign inexact = guard | rem_nz;

  always_comb begin
    unique case (mode)
      RND_NEAR: up = guard & (rem_nz | lsb);
      RND_UP:   up = guard | rem_nz;
      default:  up = 1'b0;
    endcase
  end

  // a carry out of the fraction moves into the exponent field
  assign value = {1'b0, {root_exp, root_lo[SIG_W-1:1]} + (WORD_W-1)'(up)};
endmodule

// File: rtl/fsq_sqrt_unit.sv
module fsq_sqrt_unit
  import fsq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  src2_lo,
  input  logic [UPR_W-1:0]   src1_upper,
  input  logic [WORD_W-1:0]  dst_prev_lo,
  input  logic [1:0]         csr_rc,
  input  logic               emb_round_en,
  input  logic               src_is_reg,
  input  logic [1:0]         rc_override,
  input  logic               mask_en,
  input  logic               mask_bit,
  input  logic               zero_mask,
  output logic               out_valid,
  output logic [VEC_W-1:0]   result,
  output logic               flag_invalid,
  output logic               flag_denormal,
  output logic               flag_inexact
);
  fsq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic              accept;

  logic              u_special, u_inv, u_sub;
  logic [WORD_W-1:0] u_val;
  logic [RAD_W-1:0]  u_rad;
  logic [EXP_W-1:0]  u_exp;

  logic              sp_r, sp_inv_r, den_r, wr_r, zm_r;
  logic [WORD_W-1:0] sp_val_r, prev_r;
  logic [UPR_W-1:0]  upper_r;
  logic [EXP_W-1:0]  exp_r;
  rnd_mode_t         mode_r;

  logic [SIG_W-1:0]  root_lo;
  logic              rem_nz, rnd_inx;
  logic [WORD_W-1:0] rnd_val;

  logic [WORD_W-1:0] low_n;
  logic              inv_n, den_n, inx_n;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid & in_ready;

  fsq_unpack u_unpack (
    .op(src2_lo), .special(u_special), .special_val(u_val),
    .special_inv(u_inv), .subnormal(u_sub), .radicand(u_rad),
    .root_exp(u_exp)
  );

  fsq_root_iter #(.Q_W(ROOT_W), .RAD_W(RAD_W)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(state == ST_ITER),
    .radicand_in(u_rad), .root_lo(root_lo), .rem_nz(rem_nz)
  );

  fsq_round u_round (
    .root_lo(root_lo), .rem_nz(rem_nz), .root_exp(exp_r), .mode(mode_r),
    .value(rnd_val), .inexact(rnd_inx)
  );

  // low-lane selection under the writemask
  always_comb begin
    if (wr_r) begin
      low_n = sp_r ? sp_val_r : rnd_val;
      inv_n = sp_r & sp_inv_r;
      inx_n = ~sp_r & rnd_inx;
      den_n = den_r;
    end else begin
      low_n = zm_r ? '0 : prev_r;
      inv_n = 1'b0;
      inx_n = 1'b0;
      den_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      cnt           <= '0;
      out_valid     <= 1'b0;
      result        <= '0;
      flag_invalid  <= 1'b0;
      flag_denormal <= 1'b0;
      flag_inexact  <= 1'b0;
      sp_r <= 1'b0; sp_inv_r <= 1'b0; den_r <= 1'b0; wr_r <= 1'b0; zm_r <= 1'b0;
      sp_val_r <= '0; prev_r <= '0; upper_r <= '0; exp_r <= '0;
      mode_r <= RND_NEAR;
    end else begin
      out_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          sp_r     <= u_special;
          sp_inv_r <= u_inv;
          sp_val_r <= u_val;
          den_r    <= u_sub;
          exp_r    <= u_exp;
          prev_r   <= dst_prev_lo;
          upper_r  <= src1_upper;
          wr_r     <= ~mask_en | mask_bit;
          zm_r     <= zero_mask;
          mode_r   <= rnd_mode_t'((emb_round_en && src_is_reg) ? rc_override : csr_rc);
          cnt      <= '0;
          state    <= u_special ? ST_FIN : ST_ITER;
        end
        ST_ITER: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(ROOT_W - 1)) state <= ST_FIN;
        end
        default: begin
          result        <= {upper_r, low_n};
          flag_invalid  <= inv_n;
          flag_denormal <= den_n;
          flag_inexact  <= inx_n;
          out_valid     <= 1'b1;
          state         <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/fsq_sqrt_unit_chk.sv
module fsq_sqrt_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic [127:0] result,
  input logic         flag_invalid,
  input logic         flag_denormal,
  input logic         flag_inexact
);
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_done_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_done_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  assert_hold_between_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(result) && $stable(flag_invalid)
                    && $stable(flag_denormal) && $stable(flag_inexact)));

  assert_invalid_gives_qnan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_invalid) |-> (&result[30:22]));

  assert_inexact_finite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_inexact) |-> (result[30:23] != 8'hFF && !flag_invalid));
endmodule

bind fsq_sqrt_unit fsq_sqrt_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .result(result), .flag_invalid(flag_invalid),
  .flag_denormal(flag_denormal), .flag_inexact(flag_inexact)
);

// File: tb/fsq_sqrt_unit_test.sv
`timescale 1ns/1ps
module fsq_sqrt_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  src2_lo = '0;
  logic [95:0]  src1_upper = '0;
  logic [31:0]  dst_prev_lo = '0;
  logic [1:0]   csr_rc = '0;
  logic         emb_round_en = 1'b0;
  logic         src_is_reg = 1'b0;
  logic [1:0]   rc_override = '0;
  logic         mask_en = 1'b0;
  logic         mask_bit = 1'b0;
  logic         zero_mask = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         flag_invalid, flag_denormal, flag_inexact;

  always #5 clk = ~clk;

  fsq_sqrt_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src2_lo(src2_lo), .src1_upper(src1_upper), .dst_prev_lo(dst_prev_lo),
    .csr_rc(csr_rc), .emb_round_en(emb_round_en), .src_is_reg(src_is_reg),
    .rc_override(rc_override), .mask_en(mask_en), .mask_bit(mask_bit),
    .zero_mask(zero_mask), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_denormal(flag_denormal),
    .flag_inexact(flag_inexact)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_tag = "R1";

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // behavioural model: returns {invalid, denormal, inexact, value}
  function automatic logic [34:0] ref_sqrt(input logic [31:0] x, input logic [1:0] rc);
    logic s, den, inv, inx;
    logic [7:0] e;
    logic [22:0] f;
    logic [31:0] v;
    longint m, xr, q, t, mag;
    int ee;
    logic g, st;
    s = x[31]; e = x[30:23]; f = x[22:0];
    den = (e == 0) && (f != 0);
    inv = 1'b0; inx = 1'b0; v = x;
    if (e == 8'hFF && f != 0) begin
      v = x | 32'h0040_0000; inv = ~f[22];
    end else if (e == 0 && f == 0) begin
      v = x;
    end else if (s) begin
      v = 32'hFFC0_0000; inv = 1'b1;
    end else if (e == 8'hFF) begin
      v = x;
    end else begin
      if (e == 0) begin
        m = longint'(f); ee = -126;
        while (m < (longint'(1) << 23)) begin m = m << 1; ee = ee - 1; end
      end else begin
        m = longint'(f) | (longint'(1) << 23); ee = int'(e) - 127;
      end
      if (ee % 2 != 0) begin m = m << 1; ee = ee - 1; end
      xr = m << 25;
      q = 0;
      for (int b = 25; b >= 0; b--) begin
        t = q | (longint'(1) << b);
        if (t * t <= xr) q = t;
      end
      g  = q[0];
      st = (xr != q * q);
      mag = (longint'(ee / 2 + 127) << 23) | ((q >> 1) & 64'h7F_FFFF);
      case (rc)
        2'b00: if (g && (st || q[1])) mag = mag + 1;
        2'b10: if (g || st) mag = mag + 1;
        default: ;
      endcase
      v = mag[31:0];
      inx = g | st;
    end
    return {inv, den, inx, v};
  endfunction

  function automatic bit is_special(input logic [31:0] x);
    return (x[30:23] == 8'hFF) || (x[30:0] == 0) || x[31];
  endfunction

  // cycle-by-cycle monitor, sampling at the falling edge
  int           cd = -1;
  bit           have_held = 1'b0;
  logic [127:0] exp_res, held_res;
  logic [2:0]   exp_flg, held_flg;
  string        exp_tag;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cd > 0) cd--;
      if (cd == 0) begin
        check(out_valid === 1'b1, "R10", "done pulse timing", 128'(out_valid), 128'd1);
        check(result[31:0] === exp_res[31:0], exp_tag, "low lane", result, exp_res);
        check(result[127:32] === exp_res[127:32], "R3", "upper lanes", result, exp_res);
        check(flag_invalid === exp_flg[2], exp_tag, "invalid flag", 128'(flag_invalid), 128'(exp_flg[2]));
        check(flag_denormal === exp_flg[1], "R8", "denormal flag", 128'(flag_denormal), 128'(exp_flg[1]));
        check(flag_inexact === exp_flg[0], "R9", "inexact flag", 128'(flag_inexact), 128'(exp_flg[0]));
        held_res = exp_res; held_flg = exp_flg; have_held = 1'b1;
        cd = -1;
      end else begin
        check(out_valid === 1'b0, "R10", "no pulse expected", 128'(out_valid), 128'd0);
        if (have_held) begin
          check(result === held_res, "R11", "result held", result, held_res);
          check({flag_invalid, flag_denormal, flag_inexact} === held_flg, "R11", "flags held",
                128'({flag_invalid, flag_denormal, flag_inexact}), 128'(held_flg));
        end
      end
      if (in_valid && in_ready) begin
        logic [34:0] r;
        logic [1:0]  rc;
        rc = (emb_round_en && src_is_reg) ? rc_override : csr_rc;
        r = ref_sqrt(src2_lo, rc);
        if (!mask_en || mask_bit) begin
          exp_res = {src1_upper, r[31:0]};
          exp_flg = r[34:32];
        end else begin
          exp_res = {src1_upper, zero_mask ? 32'h0 : dst_prev_lo};
          exp_flg = 3'b000;
        end
        exp_tag = cur_tag;
        cd = is_special(src2_lo) ? 2 : 27;
      end
    end
  end

  task automatic issue(input logic [31:0] x, input logic [1:0] csr, input logic emb,
                       input logic isreg, input logic [1:0] ovr, input logic men,
                       input logic mb, input logic zm, input logic [31:0] prev,
                       input string tag);
    bit acc;
    @(posedge clk); #1;
    src2_lo = x; csr_rc = csr; emb_round_en = emb; src_is_reg = isreg;
    rc_override = ovr; mask_en = men; mask_bit = mb; zero_mask = zm;
    dst_prev_lo = prev; src1_upper = {x ^ 32'hA5A5_0F0F, ~x, prev};
    cur_tag = tag;
    in_valid = 1'b1;
    acc = 1'b0;
    while (!acc) begin
      acc = in_ready;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    src2_lo = 32'hDEAD_BEEF;
  endtask

  task automatic plain(input logic [31:0] x, input logic [1:0] rc, input string tag);
    issue(x, rc, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 32'h1234_5678, tag);
  endtask

  task automatic run_all();
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R10", "idle after reset", 128'(in_ready), 128'd1);
    check(out_valid === 1'b0, "R10", "no done after reset", 128'(out_valid), 128'd0);
    check(result === 128'd0, "R11", "result zero after reset", result, 128'd0);
    // R1: exact and inexact roots, all four modes
    plain(32'h4080_0000, 2'b00, "R1");
    for (int m = 0; m < 4; m++) plain(32'h4000_0000, 2'(m), "R1");
    for (int m = 0; m < 4; m++) plain(32'h3F80_0001, 2'(m), "R1");
    plain(32'h7F7F_FFFF, 2'b10, "R1");
    plain(32'h3E80_0000, 2'b11, "R1");
    // R8: subnormal operands
    plain(32'h0000_0001, 2'b00, "R8");
    plain(32'h007F_FFFF, 2'b10, "R8");
    plain(32'h0000_0300, 2'b01, "R8");
    // R2: override taken only with embedded rounding on a register operand
    issue(32'h4000_0000, 2'b11, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 32'h0, "R2");
    issue(32'h4000_0000, 2'b11, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 32'h0, "R2");
    issue(32'h4000_0000, 2'b10, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 32'h0, "R2");
    // R6 / R5 / R7 specials
    plain(32'h0000_0000, 2'b00, "R6");
    plain(32'h8000_0000, 2'b10, "R6");
    plain(32'h7F80_0000, 2'b00, "R6");
    plain(32'hFF80_0000, 2'b00, "R5");
    plain(32'hBF80_0000, 2'b00, "R5");
    plain(32'h8000_0005, 2'b00, "R5");
    plain(32'h7FC1_2345, 2'b00, "R7");
    plain(32'h7F81_2345, 2'b00, "R7");
    plain(32'hFF80_0001, 2'b00, "R7");
    // R4 writemask: write, merge, zero, mask disabled
    issue(32'h4000_0000, 2'b00, 1'b0, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 32'hCAFE_F00D, "R4");
    issue(32'h4000_0000, 2'b00, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 32'hCAFE_F00D, "R4");
    issue(32'h0000_0001, 2'b00, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 32'hCAFE_F00D, "R4");
    issue(32'hBF80_0000, 2'b00, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 32'h0BAD_CAFE, "R4");
    issue(32'h4000_0000, 2'b00, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 32'hCAFE_F00D, "R4");
    // mixed random operations
    lf = 32'h1357_9BDF;
    for (int k = 0; k < 40; k++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      issue({k < 30 ? 1'b0 : lf[31], lf[30:0]}, lf[1:0], lf[2], lf[3], lf[5:4],
            lf[6] & lf[7], lf[8], lf[9], ~lf, "R1");
    end
    repeat (30) @(posedge clk);
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    fork
      run_all();
      begin repeat (100000) @(posedge clk); wd = 1'b1; end
    join_any
    disable fork;
    if (wd) begin
      n_checks++; n_fail++;
      $display("FAIL R10 watchdog expired: actual hung expected completion");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule